// File: doc/BRIEF.md
# Serial Clock Ratio Validator

This block watches the bit clock and the frame clock of an audio serial port that runs as a clock slave. Both clocks arrive from outside the chip. The block samples them with the local system clock and counts the bit-clock rising edges in each frame. A frame runs from one frame-clock rising edge to the next. At the end of each frame the block decides whether the count is a bit-clock-to-frame ratio that the current speed mode permits.

The result appears on three outputs:
- a 2-bit ratio code;
- a valid flag;
- a lock flag, which rises only once the measured ratio has repeated.

A port that can switch into slave mode on its own needs its own copy of the block. Any logic that must wait for a stable clock ratio can use the lock flag as its qualifier.

Top module: `sclk_ratio_check`

## Requirements
- R1: After reset, `ratio_code` is 00 and both `ratio_valid` and `ratio_locked` are low.
- R2: The bit-clock edges seen before the first frame-clock rising edge after reset are discarded. The frame that closes at that first rising edge produces no result, and all outputs stay at their reset values.
- R3: A frame's count is the number of bit-clock rising edges between two successive frame-clock rising edges. A count of 32 is reported as code 00, 48 as code 01, 64 as code 10 and 128 as code 11.
- R4: With `speed_mode` = 00 (single speed), the counts 32, 48, 64 and 128 are legal.
- R5: With `speed_mode` = 01, 10 or 11, only the counts 32, 48 and 64 are legal, and a count of 128 is reported as invalid.
- R6: Every result updates a fixed number of system clocks after the closing frame-clock edge. A legal count raises `ratio_valid` and drives its code. Any other count lowers `ratio_valid` and forces `ratio_code` to 00.
- R7: `ratio_locked` rises at the end of a frame only when that frame and the frame before it both measured the same legal ratio.
- R8: `ratio_locked` falls at the end of any frame whose count is illegal or differs from the previous frame's count.
- R9: If 256 bit-clock rising edges arrive within one frame, `ratio_valid`, `ratio_locked` and `ratio_code` clear at once, without waiting for the frame to close. That frame is then reported as illegal.
- R10: Between results, and apart from the clearing in R9, the three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_mode | input | 2 | 00 single, 01 double, 10 quad, 11 treated like double |
| sclk_in | input | 1 | External serial bit clock |
| lrck_in | input | 1 | External frame (left/right) clock |
| ratio_code | output | 2 | Measured ratio: 00=32, 01=48, 10=64, 11=128 |
| ratio_valid | output | 1 | Last result was a legal ratio for the mode |
| ratio_locked | output | 1 | Two consecutive frames measured the same legal ratio |

## Verification
The runaway frame is the hardest case to reach. The outputs must clear while the frame is still open, and the port gives no direct view of the internal counter crossing its limit. The bench first brings the block into lock with two 64-edge frames. It then drives one frame longer than 256 edges and samples the outputs a few clocks after the 258th edge, before the frame clock rises again. After that it checks that the closing edge reports the frame as illegal and that two clean frames restore lock. The other corners are covered by sweeping a list of counts around every legal ratio, in every speed mode, with the expected code, valid and lock computed arithmetically in the bench.

// File: rtl/srv_pkg.sv
package srv_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        RAT_32  = 2'b00,
        RAT_48  = 2'b01,
        RAT_64  = 2'b10,
        RAT_128 = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   legal;
        ratio_e code;
    } verdict_t;

    localparam int RATIO_A = 32;
    localparam int RATIO_B = 48;
    localparam int RATIO_C = 64;
    localparam int RATIO_D = 128;

endpackage

// File: rtl/srv_edge_sync.sv
module srv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] pipe;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[PW-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.pipe[STAGES-1] & ~q.pipe[STAGES];

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/srv_frame_counter.sv
module srv_frame_counter #(
    parameter int OVF_LIMIT = 256,
    parameter int CNT_W     = $clog2(OVF_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise,
    input  logic             frame_rise,
    output logic             frame_done,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             frame_ovf,
    output logic             ovf_event
);
    localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(OVF_LIMIT);
    localparam logic [CNT_W-1:0] BEFORE = CNT_W'(OVF_LIMIT - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             done;
        logic [CNT_W-1:0] cnt_out;
        logic             ovf_out;
        logic             ovf_evt;
    } fc_t;

    fc_t q, d;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.ovf_evt = 1'b0;
        if (frame_rise) begin
            if (q.armed) begin
                d.done    = 1'b1;
                d.cnt_out = q.cnt;
                d.ovf_out = q.ovf;
            end
            d.armed = 1'b1;
            d.cnt   = bit_rise ? CNT_W'(1) : '0;
            d.ovf   = 1'b0;
        end else if (q.armed && bit_rise && (q.cnt != LIMIT)) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == BEFORE) begin
                d.ovf     = 1'b1;
                d.ovf_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame_done = q.done;
    assign frame_cnt  = q.cnt_out;
    assign frame_ovf  = q.ovf_out;
    assign ovf_event  = q.ovf_evt;

    // R9
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LIMIT);

    // R2
    done_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.armed |=> !q.done);

    // R9
    ovf_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done && q.ovf_evt));

endmodule

// File: rtl/srv_ratio_classify.sv
module srv_ratio_classify
    import srv_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    input  logic [1:0]       mode,
    output verdict_t         verdict
);
    always_comb begin
        verdict = '{legal: 1'b0, code: RAT_32};
        if (!ovf) begin
            if (cnt == CNT_W'(RATIO_A)) begin
                verdict = '{legal: 1'b1, code: RAT_32};
            end else if (cnt == CNT_W'(RATIO_B)) begin
                verdict = '{legal: 1'b1, code: RAT_48};
            end else if (cnt == CNT_W'(RATIO_C)) begin
                verdict = '{legal: 1'b1, code: RAT_64};
            end else if (cnt == CNT_W'(RATIO_D) && mode == SPD_SINGLE) begin
                verdict = '{legal: 1'b1, code: RAT_128};
            end
        end
    end

endmodule

// File: rtl/srv_lock_tracker.sv
module srv_lock_tracker
    import srv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done,
    input  verdict_t   verdict,
    input  logic       ovf_event,
    output logic [1:0] ratio_code,
    output logic       ratio_valid,
    output logic       ratio_locked
);
    typedef struct packed {
        ratio_e code;
        logic   valid;
        logic   locked;
        logic   prev_ok;
        ratio_e prev_code;
    } lk_t;

    lk_t q, d;

    always_comb begin
        d = q;
        if (frame_done) begin
            d.valid     = verdict.legal;
            d.code      = verdict.legal ? verdict.code : RAT_32;
            d.locked    = verdict.legal && q.prev_ok && (q.prev_code == verdict.code);
            d.prev_ok   = verdict.legal;
            d.prev_code = verdict.code;
        end else if (ovf_event) begin
            d.valid   = 1'b0;
            d.code    = RAT_32;
            d.locked  = 1'b0;
            d.prev_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{code: RAT_32, valid: 1'b0, locked: 1'b0, prev_ok: 1'b0, prev_code: RAT_32};
        end else begin
            q <= d;
        end
    end

    assign ratio_code   = q.code;
    assign ratio_valid  = q.valid;
    assign ratio_locked = q.locked;

    // R7
    lock_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_locked |-> ratio_valid);

    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !verdict.legal) |=> !ratio_locked);

    // R9
    ovf_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_event |=> (!ratio_valid && !ratio_locked && ratio_code == 2'b00));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !ovf_event) |=> $stable({ratio_code, ratio_valid, ratio_locked}));

endmodule

// File: rtl/sclk_ratio_check.sv
module sclk_ratio_check
    import srv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OVF_LIMIT   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_mode,
    input  logic       sclk_in,
    input  logic       lrck_in,
    output logic [1:0] ratio_code,
    output logic       ratio_valid,
    output logic       ratio_locked
);
    localparam int CNT_W = $clog2(OVF_LIMIT + 1);

    logic             bit_rise;
    logic             frame_rise;
    logic             frame_done;
    logic [CNT_W-1:0] frame_cnt;
    logic             frame_ovf;
    logic             ovf_event;
    verdict_t         verdict;

    srv_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (sclk_in),
        .rise (bit_rise)
    );

    srv_edge_sync #(.STAGES(SYNC_STAGES)) u_lrck_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (lrck_in),
        .rise (frame_rise)
    );

    srv_frame_counter #(.OVF_LIMIT(OVF_LIMIT), .CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bit_rise),
        .frame_rise (frame_rise),
        .frame_done (frame_done),
        .frame_cnt  (frame_cnt),
        .frame_ovf  (frame_ovf),
        .ovf_event  (ovf_event)
    );

    srv_ratio_classify #(.CNT_W(CNT_W)) u_classify (
        .cnt     (frame_cnt),
        .ovf     (frame_ovf),
        .mode    (speed_mode),
        .verdict (verdict)
    );

    srv_lock_tracker u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .verdict      (verdict),
        .ovf_event    (ovf_event),
        .ratio_code   (ratio_code),
        .ratio_valid  (ratio_valid),
        .ratio_locked (ratio_locked)
    );

    // R5
    no128_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && verdict.legal && verdict.code == RAT_128) |-> (speed_mode == SPD_SINGLE));

    // R6
    code_zero_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_valid |-> (ratio_code == 2'b00));

endmodule

// File: tb/sclk_ratio_check_tb_top.sv
`timescale 1ns/1ps
module sclk_ratio_check_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic       sclk_in = 1'b0;
    logic       lrck_in = 1'b0;
    logic [1:0] ratio_code;
    logic       ratio_valid;
    logic       ratio_locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model state
    bit         armed_m;
    int         last_n;
    bit         prev_ok_m;
    logic [1:0] prev_code_m;
    logic [1:0] exp_code;
    bit         exp_valid;
    bit         exp_lock;
    string      exp_tag;

    always #10 clk = ~clk;

    sclk_ratio_check dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .speed_mode   (speed_mode),
        .sclk_in      (sclk_in),
        .lrck_in      (lrck_in),
        .ratio_code   (ratio_code),
        .ratio_valid  (ratio_valid),
        .ratio_locked (ratio_locked)
    );

    task automatic check(string tag);
        n_checks++;
        if (ratio_code !== exp_code || ratio_valid !== exp_valid || ratio_locked !== exp_lock) begin
            n_fail++;
            $display("FAIL %s: actual code=%0b valid=%0b lock=%0b expected code=%0b valid=%0b lock=%0b",
                     tag, ratio_code, ratio_valid, ratio_locked, exp_code, exp_valid, exp_lock);
        end
    endtask

    task automatic model_end(int n);
        bit         legal;
        logic [1:0] c;
        bit         was_lock;
        legal = 1'b1;
        c = 2'b00;
        if (n == 32)                            c = 2'b00;
        else if (n == 48)                       c = 2'b01;
        else if (n == 64)                       c = 2'b10;
        else if (n == 128 && speed_mode == 2'b00) c = 2'b11;
        else legal = 1'b0;
        was_lock  = exp_lock;
        exp_valid = legal;
        exp_code  = legal ? c : 2'b00;
        exp_lock  = legal && prev_ok_m && (prev_code_m == c);
        prev_ok_m   = legal;
        prev_code_m = c;
        if (n >= 256)                  exp_tag = "R9 runaway frame illegal";
        else if (exp_lock && !was_lock) exp_tag = "R7 lock rise";
        else if (!exp_lock && was_lock) exp_tag = "R8 lock drop";
        else if (n == 128)             exp_tag = (speed_mode == 2'b00) ? "R4 128 single" : "R5 128 fast";
        else if (legal)                exp_tag = "R3 legal ratio";
        else                           exp_tag = "R6 illegal count";
    endtask

    task automatic pulses(int n, int lr_fall_at);
        for (int i = 0; i < n; i++) begin
            if (i == lr_fall_at) lrck_in = 1'b0;
            @(negedge clk) sclk_in = 1'b1;
            @(negedge clk);
            @(negedge clk) sclk_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic frame_open();
        @(negedge clk) lrck_in = 1'b1;
        repeat (8) @(negedge clk);
        if (armed_m) begin
            model_end(last_n);
            check(exp_tag);
        end else begin
            exp_code = 2'b00; exp_valid = 1'b0; exp_lock = 1'b0;
            check("R2 first partial frame ignored");
        end
        armed_m = 1'b1;
    endtask

    task automatic frame(int n);
        frame_open();
        pulses(n, n / 2);
        last_n = n;
    endtask

    task automatic do_reset(logic [1:0] m);
        rst_n = 1'b0; sclk_in = 1'b0; lrck_in = 1'b0; speed_mode = m;
        armed_m = 1'b0; prev_ok_m = 1'b0; prev_code_m = 2'b00;
        exp_code = 2'b00; exp_valid = 1'b0; exp_lock = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset state");
    endtask

    int seq [24] = '{32, 32, 48, 48, 64, 64, 128, 128, 33, 64, 64, 48,
                     31, 47, 49, 63, 65, 127, 129, 16, 96, 200, 64, 64};

    initial begin
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m));
            pulses(20, -1);           // partial frame before first frame edge (R2)
            foreach (seq[k]) frame(seq[k]);
            frame(32);
        end
        // runaway frame in single speed (R9)
        do_reset(2'b00);
        frame(64);
        frame(64);
        frame(64);
        frame_open();                 // closes a 64 frame: still locked
        pulses(258, 100);
        repeat (6) @(negedge clk);
        exp_code = 2'b00; exp_valid = 1'b0; exp_lock = 1'b0;
        prev_ok_m = 1'b0;
        check("R9 outputs cleared mid frame");
        pulses(2, -1);
        last_n = 260;
        frame(64);                    // reports the runaway frame illegal
        frame(64);
        frame(64);                    // relock
        frame(32);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule